// File: doc/BRIEF.md
# Serial Line Auto-Baud Synchroniser

After reset, this block watches an idle-high serial receive line for the host's synchronisation character, 0x7F. The character is framed with one start bit, eight data bits sent LSB first and one stop bit. The falling edge at the start bit and the falling edge at the last data bit are eight bit-times apart. A 16-bit counter running on the system clock measures that gap. The block divides the count by eight with rounding to nearest and presents the result as a per-bit clock divisor. A UART then uses that divisor for 8-data-bit, no-parity, 1-stop-bit traffic.

A good measurement gives a one-cycle valid strobe and raises a request to send the acknowledge byte 0x75. That request stays up until the transmitter grants it. The measurement fails in two cases: the counter reaches its ceiling before the second edge arrives, or the rounded divisor comes out as zero. A failure raises a sticky error flag and no divisor is produced. Once the block has either succeeded or failed, it ignores the line until reset.

Top module: `autobaud_sync`

## Requirements
- R1: In the cycle after a synchronous reset, div_o is 0 and div_vld_o, err_o and ack_req_o are all low.
- R2: A falling edge on rx_i while en_i is low starts no measurement, and all outputs stay at their reset values.
- R3: The measured count is the number of clock cycles between the two falling edges on rx_i. div_o is (count + 4) >> 3, so a 0x7F frame with a bit period of P cycles yields P.
- R4: div_vld_o is high for exactly one cycle. It rises on the same clock edge that loads div_o. That is the third rising edge counted from the first edge that samples the second falling edge low (two synchroniser flops and one result register).
- R5: When no second falling edge arrives, err_o goes high on the edge where the count would pass 65535, and div_vld_o never pulses. A count of exactly 65535 is accepted and gives div_o = 8192.
- R6: A count that rounds to a zero divisor (count below 4) sets err_o with no divisor. A count of 4 gives div_o = 1.
- R7: err_o stays high until reset, and rx_i edges after an error have no effect.
- R8: After a successful sync, further rx_i edges change neither div_o nor div_vld_o until reset.
- R9: ack_req_o rises together with div_vld_o, and ack_data_o is 0x75. ack_req_o holds while ack_gnt_i is low and clears on the rising edge where ack_gnt_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Allows a measurement to start |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| ack_gnt_i | input | 1 | Transmitter has taken the acknowledge byte |
| div_o | output | 14 | Learned per-bit divisor in clock cycles |
| div_vld_o | output | 1 | One-cycle strobe when div_o is loaded |
| err_o | output | 1 | Sticky sync failure flag |
| ack_req_o | output | 1 | Request to transmit the acknowledge byte |
| ack_data_o | output | 8 | Acknowledge byte to transmit |

## Verification
The block is driven with these input patterns:
- A genuine 0x7F frame. This shows that the two counted edges are the start bit and the last data bit, and not any intermediate transition.
- Bare edge pairs 643 and 644 cycles apart. These separate round-to-nearest from truncation.
- Gaps of 3 and 4 cycles, and of 65535 cycles against a lone edge. These place the zero-divisor and overflow limits exactly.
- Edges sent while disabled, after success and after failure. These show that the one-shot behaviour and the enable gate hold.

A behavioural model in the bench is compared against every output on every clock.

// File: rtl/ab_pkg.sv
// Shared types and constants for the auto-baud synchroniser.
// Assumes: nothing beyond IEEE 1800-2017.
package ab_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_DONE = 2'd2,
        ST_FAIL = 2'd3
    } ab_state_e;

    localparam logic [7:0] ACK_BYTE = 8'h75;
endpackage

// File: rtl/ab_rx_sync.sv
// Brings the asynchronous receive line into the clock domain and flags
// falling edges. Assumes STAGES >= 2 and an idle-high line (flops reset to 1).
module ab_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Metastability chain, newest sample at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], line_i};
    end

    // Previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain_q[STAGES-1];
    end

    assign fall_o = last_q & ~chain_q[STAGES-1];

    // R3
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/ab_edge_timer.sv
// Edge-to-edge cycle counter. A clear loads 1 because the clear cycle is
// itself the first elapsed cycle. Assumes the caller never increments at max.
module ab_edge_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_max_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load on clear, otherwise step when told to.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= CNT_W'(1);
        else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt_o    = cnt_q;
    assign at_max_o = &cnt_q;

    // R5
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !(&cnt_q));
endmodule

// File: rtl/ab_div_round.sv
// Turns an edge-gap count covering 2**SHIFT bit-times into a per-bit
// divisor, rounded to nearest (half rounds up). Purely combinational.
module ab_div_round #(
    parameter int CNT_W = 16,
    parameter int SHIFT = 3,
    localparam int DIV_W = CNT_W - SHIFT + 1
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [DIV_W-1:0] div_o
);
    localparam int HALF = 1 << (SHIFT - 1);

    logic [CNT_W:0] sum;

    // Add half a step, keep the upper bits.
    always_comb begin
        sum   = {1'b0, cnt_i} + (CNT_W+1)'(HALF);
        div_o = sum[CNT_W:SHIFT];
    end
endmodule

// File: rtl/autobaud_sync.sv
// Auto-baud synchroniser: measures one 0x7F sync character on rx_i,
// produces a rounded per-bit divisor, flags overflow or zero divisor,
// and requests transmission of the acknowledge byte. One shot per reset.
// Assumes: rx_i idle high, en_i and ack_gnt_i synchronous to clk.
module autobaud_sync #(
    parameter int CNT_W       = 16,
    parameter int SHIFT       = 3,
    parameter int SYNC_STAGES = 2,
    localparam int DIV_W      = CNT_W - SHIFT + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             rx_i,
    input  logic             ack_gnt_i,
    output logic [DIV_W-1:0] div_o,
    output logic             div_vld_o,
    output logic             err_o,
    output logic             ack_req_o,
    output logic [7:0]       ack_data_o
);
    import ab_pkg::*;

    ab_state_e        st_q, st_d;
    logic             fall;
    logic             tmr_clr, tmr_inc, tmr_max;
    logic [CNT_W-1:0] tmr_cnt;
    logic [DIV_W-1:0] div_calc;
    logic             take, fail;
    logic [DIV_W-1:0] div_q;
    logic             vld_q, err_q, req_q;

    ab_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_i),
        .fall_o (fall)
    );

    ab_edge_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (tmr_clr),
        .inc_i    (tmr_inc),
        .cnt_o    (tmr_cnt),
        .at_max_o (tmr_max)
    );

    ab_div_round #(.CNT_W(CNT_W), .SHIFT(SHIFT)) u_round (
        .cnt_i (tmr_cnt),
        .div_o (div_calc)
    );

    // Sequencing: wait for the first edge, time until the second, then stop.
    always_comb begin
        st_d    = st_q;
        tmr_clr = 1'b0;
        tmr_inc = 1'b0;
        take    = 1'b0;
        fail    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (en_i && fall) begin
                    st_d    = ST_MEAS;
                    tmr_clr = 1'b1;
                end
            end
            ST_MEAS: begin
                if (fall) begin
                    if (div_calc == '0) begin
                        st_d = ST_FAIL;
                        fail = 1'b1;
                    end else begin
                        st_d = ST_DONE;
                        take = 1'b1;
                    end
                end else if (tmr_max) begin
                    st_d = ST_FAIL;
                    fail = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Divisor capture and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= take;
            if (take) div_q <= div_calc;
        end
    end

    // Sticky failure flag.
    always_ff @(posedge clk) begin
        if (!rst_n)    err_q <= 1'b0;
        else if (fail) err_q <= 1'b1;
    end

    // Acknowledge request, held until granted.
    always_ff @(posedge clk) begin
        if (!rst_n)         req_q <= 1'b0;
        else if (take)      req_q <= 1'b1;
        else if (ack_gnt_i) req_q <= 1'b0;
    end

    assign div_o      = div_q;
    assign div_vld_o  = vld_q;
    assign err_o      = err_q;
    assign ack_req_o  = req_q;
    assign ack_data_o = ACK_BYTE;

    // R4
    vld_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_vld_o |=> !div_vld_o);

    // R5
    vld_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_vld_o |-> !err_o);

    // R6
    vld_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_vld_o |-> (div_o != '0));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !div_vld_o |=> (!div_vld_o || (st_q != ST_DONE)) ? $stable(div_o) : 1'b1);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req_o && !ack_gnt_i) |=> ack_req_o);

    // R9
    req_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req_o) |-> div_vld_o);
endmodule

// File: tb/autobaud_sync_tb_top.sv
`timescale 1ns/1ps
module autobaud_sync_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic        rx_i = 1'b1;
    logic        ack_gnt_i = 1'b0;
    logic [13:0] div_o;
    logic        div_vld_o, err_o, ack_req_o;
    logic [7:0]  ack_data_o;

    int checks = 0;
    int errors = 0;
    int vld_cnt = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // Reference model state.
    int hist[$];
    int m_st = 0;
    int m_cnt = 0;
    int e_div = 0, e_vld = 0, e_err = 0, e_req = 0;

    always #4 clk = ~clk;

    autobaud_sync dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .rx_i(rx_i),
        .ack_gnt_i(ack_gnt_i), .div_o(div_o), .div_vld_o(div_vld_o),
        .err_o(err_o), .ack_req_o(ack_req_o), .ack_data_o(ack_data_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, updated on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{1, 1, 1};
            m_st = 0; m_cnt = 0;
            e_div = 0; e_vld = 0; e_err = 0; e_req = 0;
        end else begin
            bit f;
            f = (hist[2] == 1) && (hist[1] == 0);
            e_vld = 0;
            if (e_req == 1 && ack_gnt_i) e_req = 0;
            if (m_st == 0) begin
                if (en_i && f) begin m_st = 1; m_cnt = 1; end
            end else if (m_st == 1) begin
                if (f) begin
                    if ((m_cnt + 4) / 8 == 0) begin m_st = 3; e_err = 1; end
                    else begin
                        m_st = 2; e_div = (m_cnt + 4) / 8; e_vld = 1; e_req = 1;
                    end
                end else if (m_cnt == 65535) begin
                    m_st = 3; e_err = 1;
                end else m_cnt++;
            end
            hist.push_front(int'(rx_i));
            void'(hist.pop_back());
        end
        if (rst_n && div_vld_o) vld_cnt++;
    end

    // Every-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R3 div_o", int'(div_o), e_div);
            chk("R4 div_vld_o", int'(div_vld_o), e_vld);
            chk("R5 err_o", int'(err_o), e_err);
            chk("R9 ack_req_o", int'(ack_req_o), e_req);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        cmp_on = 1'b0;
        rst_n = 1'b0; rx_i = 1'b1; ack_gnt_i = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        vld_cnt = 0;
        cmp_on = 1'b1;
    endtask

    // Two falling edges exactly n cycles apart (n >= 3).
    task automatic send_gap(input int n);
        rx_i = 1'b0; cyc(2);
        rx_i = 1'b1; cyc(n - 2);
        rx_i = 1'b0; cyc(2);
        rx_i = 1'b1; cyc(6);
    endtask

    // Full frame: start, 8 data bits LSB first, stop; p cycles per bit.
    task automatic send_frame(input logic [7:0] b, input int p);
        rx_i = 1'b0; cyc(p);
        for (int i = 0; i < 8; i++) begin rx_i = b[i]; cyc(p); end
        rx_i = 1'b1; cyc(p);
    endtask

    initial begin
        do_reset();
        cyc(1);
        // R1 reset state
        chk("R1 div", int'(div_o), 0);
        chk("R1 flags", int'({div_vld_o, err_o, ack_req_o}), 0);

        // R2 edges while disabled
        send_gap(100);
        chk("R2 div", int'(div_o), 0);
        chk("R2 vld count", vld_cnt, 0);
        chk("R2 req", int'(ack_req_o), 0);

        // R3 real sync frame, bit period 80
        en_i = 1'b1;
        send_frame(8'h7F, 80);
        chk("R3 frame div", int'(div_o), 80);
        chk("R4 single strobe", vld_cnt, 1);
        chk("R9 ack data", int'(ack_data_o), 8'h75);
        cyc(5);
        chk("R9 req held", int'(ack_req_o), 1);
        ack_gnt_i = 1'b1; cyc(1); ack_gnt_i = 1'b0; cyc(1);
        chk("R9 req cleared", int'(ack_req_o), 0);

        // R8 further edges ignored
        send_gap(200);
        chk("R8 div held", int'(div_o), 80);
        chk("R8 no new strobe", vld_cnt, 1);

        // R3 rounding
        do_reset(); send_gap(643);
        chk("R3 round down", int'(div_o), 80);
        do_reset(); send_gap(644);
        chk("R3 round half up", int'(div_o), 81);

        // R6 zero divisor
        do_reset(); send_gap(3);
        chk("R6 err", int'(err_o), 1);
        chk("R6 no strobe", vld_cnt, 0);
        // R7 sticky, later edges ignored
        send_gap(100);
        chk("R7 err held", int'(err_o), 1);
        chk("R7 no strobe", vld_cnt, 0);
        do_reset(); cyc(1);
        chk("R7 err cleared", int'(err_o), 0);
        send_gap(4);
        chk("R6 boundary div", int'(div_o), 1);

        // R5 boundary and overflow
        do_reset(); send_gap(65535);
        chk("R5 max count div", int'(div_o), 8192);
        chk("R5 max count err", int'(err_o), 0);
        do_reset();
        rx_i = 1'b0; cyc(2); rx_i = 1'b1;
        cyc(65545);
        chk("R5 overflow err", int'(err_o), 1);
        chk("R5 overflow no strobe", vld_cnt, 0);

        done = 1'b1;
        cmp_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule